// File: doc/BRIEF.md
# Frame Check Sequence Engine

This block adds and verifies the 16-bit frame check sequence of byte-oriented frames in both directions of a link. The transmit side forwards payload bytes from an upstream source to a downstream sink. After the last payload byte it inserts two check octets, unless the frame was started with the suppress input high. The receive side forwards every incoming byte unchanged. It runs the same CRC over the whole frame and, once the frame is over, reports whether its final two octets matched the CRC of the bytes before them.

Both directions are valid/ready byte streams, and each beat carries start-of-frame and end-of-frame markers. A beat moves on a clock edge where valid and ready are both high. A source holds its data and markers steady until its beat is accepted. On transmit, upstream ready follows downstream ready while payload is passing. Upstream ready is held low for the two cycles in which the check octets are offered. On receive, upstream ready is always a copy of downstream ready. The receive status is a set of plain single-cycle pulses.

Top module: `fcs_engine`

## Requirements
- R1: The CRC uses the generator x^16 + x^12 + x^5 + 1 (reflected constant 0x8408) with a start value of 0x0000 and no final inversion, feeding bits LSB first within each byte. The nine ASCII bytes "123456789" yield 0x2189.
- R2: When not suppressed, a transmitted frame is its payload followed by two check octets, low octet first. The end marker sits only on the high check octet, and the start marker only on the first payload byte.
- R3: `tx_no_fcs` is sampled on the start-of-frame beat. If it is high, the frame goes out as its payload only, with the end marker on the last payload byte. Changes to `tx_no_fcs` later in the frame have no effect.
- R4: `s_tx_ready` is never high while `m_tx_ready` is low. No upstream byte is accepted while check octets are being offered. Stalls do not alter or lose any byte.
- R5: The receive stream passes through unchanged: `m_rx_*` copy `s_rx_*`, and `s_rx_ready` copies `m_rx_ready`.
- R6: In the cycle after the end-of-frame beat is accepted on receive, `rx_done` pulses for one cycle with exactly one of `rx_fcs_ok` or `rx_fcs_err`. Both flags are low whenever `rx_done` is low.
- R7: A received frame is good when its last two octets, read low first, equal the CRC of all bytes before them. Any other frame is an error. A two-octet frame of 0x00 0x00 is good.
- R8: A received frame of fewer than two octets reports an error.
- R9: The CRC restarts on every start-of-frame beat, including one that arrives before the previous frame ended. No state carries from one frame to the next.
- R10: After reset, the transmit output is idle while its input is idle, and all receive status outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| s_tx_valid | input | 1 | Transmit payload byte valid |
| s_tx_ready | output | 1 | Transmit payload byte accepted |
| s_tx_data | input | 8 | Transmit payload byte |
| s_tx_sof | input | 1 | First byte of a transmit frame |
| s_tx_eof | input | 1 | Last payload byte of a transmit frame |
| tx_no_fcs | input | 1 | Send this frame without check octets (read at start) |
| m_tx_valid | output | 1 | Outgoing byte valid |
| m_tx_ready | input | 1 | Downstream accepts outgoing byte |
| m_tx_data | output | 8 | Outgoing byte |
| m_tx_sof | output | 1 | Outgoing first byte |
| m_tx_eof | output | 1 | Outgoing last byte |
| s_rx_valid | input | 1 | Received byte valid |
| s_rx_ready | output | 1 | Received byte accepted |
| s_rx_data | input | 8 | Received byte |
| s_rx_sof | input | 1 | First received byte of a frame |
| s_rx_eof | input | 1 | Last received byte of a frame |
| m_rx_valid | output | 1 | Forwarded byte valid |
| m_rx_ready | input | 1 | Downstream accepts forwarded byte |
| m_rx_data | output | 8 | Forwarded byte |
| m_rx_sof | output | 1 | Forwarded first byte |
| m_rx_eof | output | 1 | Forwarded last byte |
| rx_done | output | 1 | One-cycle end-of-reception event |
| rx_fcs_ok | output | 1 | Check octets matched (with rx_done) |
| rx_fcs_err | output | 1 | Check octets mismatched or frame too short (with rx_done) |

## Verification
The bench builds the engine with its default parameters: reflected generator 0x8408 and start value zero. This makes the published check value for "123456789" reachable as a direct end-to-end test of bit order and octet order. With a zero start value, an all-zero two-octet frame counts as a correct frame. This lets the bench probe the boundary between the short-frame rule and the comparison itself. Alternating downstream ready patterns bring the stall paths of both directions into reach, including a stall that lands on a check octet.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  localparam int BYTE_W = 8;
  localparam int CRC_W  = 16;
  localparam int FCS_BYTES = CRC_W / BYTE_W;

  typedef logic [CRC_W-1:0]  crc_t;
  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic [1:0] {
    TX_PASS   = 2'd0,
    TX_FCS_LO = 2'd1,
    TX_FCS_HI = 2'd2
  } tx_state_e;

  // Advance a reflected CRC by one byte, least-significant bit first.
  function automatic crc_t crc_step(input crc_t cur, input byte_t din, input crc_t poly_r);
    crc_t r;
    r = cur;
    for (int i = 0; i < BYTE_W; i++) begin
      if (r[0] ^ din[i]) r = (r >> 1) ^ poly_r;
      else               r = r >> 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/fcs_tx_path.sv
module fcs_tx_path
  import fcs_pkg::*;
#(
  parameter crc_t POLY_R = 16'h8408,
  parameter crc_t INIT   = 16'h0000
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  s_valid,
  output logic  s_ready,
  input  byte_t s_data,
  input  logic  s_sof,
  input  logic  s_eof,
  input  logic  no_fcs,
  output logic  m_valid,
  input  logic  m_ready,
  output byte_t m_data,
  output logic  m_sof,
  output logic  m_eof
);
  tx_state_e state_q;
  crc_t      crc_q;
  logic      sup_q;
  logic      sup_eff;
  logic      hs_in;

  // Suppress is taken live on the start beat, from the latch afterwards.
  assign sup_eff = s_sof ? no_fcs : sup_q;
  assign hs_in   = s_valid && s_ready;

  always_comb begin
    s_ready = 1'b0;
    m_valid = 1'b0;
    m_data  = '0;
    m_sof   = 1'b0;
    m_eof   = 1'b0;
    case (state_q)
      TX_PASS: begin
        m_valid = s_valid;
        s_ready = m_ready;
        m_data  = s_data;
        m_sof   = s_sof;
        m_eof   = s_eof && sup_eff;
      end
      TX_FCS_LO: begin
        m_valid = 1'b1;
        m_data  = crc_q[BYTE_W-1:0];
      end
      TX_FCS_HI: begin
        m_valid = 1'b1;
        m_data  = crc_q[CRC_W-1:BYTE_W];
        m_eof   = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TX_PASS;
      crc_q   <= INIT;
      sup_q   <= 1'b0;
    end else begin
      case (state_q)
        TX_PASS: begin
          if (hs_in) begin
            crc_q <= crc_step(s_sof ? INIT : crc_q, s_data, POLY_R);
            if (s_sof) sup_q <= no_fcs;
            if (s_eof && !sup_eff) state_q <= TX_FCS_LO;
          end
        end
        TX_FCS_LO: if (m_ready) state_q <= TX_FCS_HI;
        TX_FCS_HI: if (m_ready) state_q <= TX_PASS;
        default:   state_q <= TX_PASS;
      endcase
    end
  end
endmodule

// File: rtl/fcs_rx_path.sv
module fcs_rx_path
  import fcs_pkg::*;
#(
  parameter crc_t POLY_R = 16'h8408,
  parameter crc_t INIT   = 16'h0000
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  s_valid,
  output logic  s_ready,
  input  byte_t s_data,
  input  logic  s_sof,
  input  logic  s_eof,
  output logic  m_valid,
  input  logic  m_ready,
  output byte_t m_data,
  output logic  m_sof,
  output logic  m_eof,
  output logic  done,
  output logic  ok,
  output logic  err
);
  localparam int CNT_W = $clog2(FCS_BYTES + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FCS_BYTES);

  crc_t            crc_q, crc_nxt;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic            hs;
  logic            good;

  assign m_valid = s_valid;
  assign m_data  = s_data;
  assign m_sof   = s_sof;
  assign m_eof   = s_eof;
  assign s_ready = m_ready;
  assign hs      = s_valid && m_ready;

  // Running the CRC across the check octets too leaves a zero residue
  // exactly when they equal the CRC of the bytes in front of them.
  always_comb begin
    crc_nxt = crc_step(s_sof ? INIT : crc_q, s_data, POLY_R);
    if (s_sof)                cnt_nxt = CNT_W'(1);
    else if (cnt_q == CNT_FULL) cnt_nxt = cnt_q;
    else                      cnt_nxt = cnt_q + CNT_W'(1);
    good = (crc_nxt == '0) && (cnt_nxt == CNT_FULL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= INIT;
      cnt_q <= '0;
      done  <= 1'b0;
      ok    <= 1'b0;
      err   <= 1'b0;
    end else begin
      done <= hs && s_eof;
      ok   <= hs && s_eof && good;
      err  <= hs && s_eof && !good;
      if (hs) begin
        crc_q <= crc_nxt;
        cnt_q <= cnt_nxt;
      end
    end
  end
endmodule

// File: rtl/fcs_engine.sv
module fcs_engine
  import fcs_pkg::*;
#(
  parameter crc_t POLY_R   = 16'h8408,
  parameter crc_t CRC_INIT = 16'h0000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       s_tx_valid,
  output logic       s_tx_ready,
  input  logic [7:0] s_tx_data,
  input  logic       s_tx_sof,
  input  logic       s_tx_eof,
  input  logic       tx_no_fcs,
  output logic       m_tx_valid,
  input  logic       m_tx_ready,
  output logic [7:0] m_tx_data,
  output logic       m_tx_sof,
  output logic       m_tx_eof,
  input  logic       s_rx_valid,
  output logic       s_rx_ready,
  input  logic [7:0] s_rx_data,
  input  logic       s_rx_sof,
  input  logic       s_rx_eof,
  output logic       m_rx_valid,
  input  logic       m_rx_ready,
  output logic [7:0] m_rx_data,
  output logic       m_rx_sof,
  output logic       m_rx_eof,
  output logic       rx_done,
  output logic       rx_fcs_ok,
  output logic       rx_fcs_err
);
  fcs_tx_path #(.POLY_R(POLY_R), .INIT(CRC_INIT)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .s_valid(s_tx_valid), .s_ready(s_tx_ready), .s_data(s_tx_data),
    .s_sof(s_tx_sof), .s_eof(s_tx_eof), .no_fcs(tx_no_fcs),
    .m_valid(m_tx_valid), .m_ready(m_tx_ready), .m_data(m_tx_data),
    .m_sof(m_tx_sof), .m_eof(m_tx_eof)
  );

  fcs_rx_path #(.POLY_R(POLY_R), .INIT(CRC_INIT)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .s_valid(s_rx_valid), .s_ready(s_rx_ready), .s_data(s_rx_data),
    .s_sof(s_rx_sof), .s_eof(s_rx_eof),
    .m_valid(m_rx_valid), .m_ready(m_rx_ready), .m_data(m_rx_data),
    .m_sof(m_rx_sof), .m_eof(m_rx_eof),
    .done(rx_done), .ok(rx_fcs_ok), .err(rx_fcs_err)
  );
endmodule

// File: rtl/fcs_engine_chk.sv
module fcs_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic s_tx_valid,
  input logic s_tx_ready,
  input logic s_tx_eof,
  input logic m_tx_valid,
  input logic m_tx_ready,
  input logic m_tx_eof,
  input logic s_rx_valid,
  input logic s_rx_ready,
  input logic s_rx_eof,
  input logic rx_done,
  input logic rx_fcs_ok,
  input logic rx_fcs_err
);
  assert_rx_single_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> ($countones({rx_fcs_ok, rx_fcs_err}) == 1));

  assert_rx_flags_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_done |-> (!rx_fcs_ok && !rx_fcs_err));

  assert_rx_event_after_eof_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (s_rx_valid && s_rx_ready && s_rx_eof) |=> rx_done);

  assert_tx_no_ready_when_blocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    s_tx_ready |-> m_tx_ready);

  assert_tx_fcs_follows_payload_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (s_tx_valid && s_tx_ready && s_tx_eof && !m_tx_eof) |=> (m_tx_valid && !s_tx_ready));
endmodule

bind fcs_engine fcs_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .s_tx_valid(s_tx_valid), .s_tx_ready(s_tx_ready), .s_tx_eof(s_tx_eof),
  .m_tx_valid(m_tx_valid), .m_tx_ready(m_tx_ready), .m_tx_eof(m_tx_eof),
  .s_rx_valid(s_rx_valid), .s_rx_ready(s_rx_ready), .s_rx_eof(s_rx_eof),
  .rx_done(rx_done), .rx_fcs_ok(rx_fcs_ok), .rx_fcs_err(rx_fcs_err)
);

// File: tb/sim_fcs_engine.sv
module sim_fcs_engine;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic       s_tx_valid = 0, s_tx_sof = 0, s_tx_eof = 0, tx_no_fcs = 0, m_tx_ready = 0;
  logic [7:0] s_tx_data = 0;
  logic       s_tx_ready, m_tx_valid, m_tx_sof, m_tx_eof;
  logic [7:0] m_tx_data;
  logic       s_rx_valid = 0, s_rx_sof = 0, s_rx_eof = 0, m_rx_ready = 0;
  logic [7:0] s_rx_data = 0;
  logic       s_rx_ready, m_rx_valid, m_rx_sof, m_rx_eof;
  logic [7:0] m_rx_data;
  logic       rx_done, rx_fcs_ok, rx_fcs_err;

  fcs_engine u0 (.*);

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [7:0] fr  [0:31];
  logic [7:0] got [0:63];
  logic       gsof[0:63];
  logic       geof[0:63];
  int         got_n;

  task automatic check(input bit cond, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc(input int n);
    logic [15:0] c;
    c = 16'h0000;
    for (int i = 0; i < n; i++) begin
      c = c ^ {8'h00, fr[i]};
      for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 16'h8408) : (c >> 1);
    end
    return c;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // Transmit one frame of len bytes from fr; bp>0 stalls downstream every bp cycles.
  task automatic run_tx(input int len, input logic sup, input logic flip, input int bp,
                        input string req);
    int idx = 0;
    int cyc = 0;
    bit fin = 0;
    bit bad_rdy = 0;
    bit mism = 0;
    int exp_n;
    logic [15:0] c;
    got_n = 0;
    while (!fin) begin
      @(negedge clk);
      if (idx < len) begin
        s_tx_valid = 1; s_tx_data = fr[idx];
        s_tx_sof = (idx == 0); s_tx_eof = (idx == len - 1);
        tx_no_fcs = (idx == 0) ? sup : (flip ? ~sup : sup);
      end else begin
        s_tx_valid = 0; s_tx_sof = 0; s_tx_eof = 0;
      end
      m_tx_ready = (bp == 0) ? 1'b1 : ((cyc % bp) != 0);
      cyc++;
      #1;
      if (s_tx_ready && !m_tx_ready) bad_rdy = 1;
      if (m_tx_valid && m_tx_ready && got_n < 64) begin
        got[got_n] = m_tx_data; gsof[got_n] = m_tx_sof; geof[got_n] = m_tx_eof;
        got_n++;
        if (m_tx_eof) fin = 1;
      end
      if (s_tx_valid && s_tx_ready) idx++;
    end
    @(negedge clk);
    s_tx_valid = 0; s_tx_sof = 0; s_tx_eof = 0; tx_no_fcs = 0;
    c = ref_crc(len);
    exp_n = sup ? len : len + 2;
    check(got_n == exp_n, req, "tx output length", got_n, exp_n);
    for (int i = 0; i < got_n && i < exp_n; i++) begin
      logic [7:0] e;
      e = (i < len) ? fr[i] : ((i == len) ? c[7:0] : c[15:8]);
      if (got[i] !== e || gsof[i] !== (i == 0) || geof[i] !== (i == exp_n - 1)) mism = 1;
    end
    check(!mism, req, "tx bytes and markers", got_n, exp_n);
    check(!bad_rdy, "R4", "upstream ready while downstream stalled", 1, 0);
  endtask

  // Receive fr[0..len-1]; eof=0 leaves the frame open (abort case).
  task automatic run_rx(input int len, input bit eof, input int bp, input string req);
    int idx = 0;
    int cyc = 0;
    bit pass_bad = 0;
    bit early = 0;
    bit exp_good;
    while (idx < len) begin
      @(negedge clk);
      s_rx_valid = 1; s_rx_data = fr[idx];
      s_rx_sof = (idx == 0); s_rx_eof = eof && (idx == len - 1);
      m_rx_ready = (bp == 0) ? 1'b1 : ((cyc % bp) != 0);
      cyc++;
      #1;
      if (m_rx_valid !== s_rx_valid || m_rx_data !== s_rx_data || m_rx_sof !== s_rx_sof ||
          m_rx_eof !== s_rx_eof || s_rx_ready !== m_rx_ready) pass_bad = 1;
      if (rx_done && idx > 0) early = 1;
      if (s_rx_valid && s_rx_ready) idx++;
    end
    check(!pass_bad, "R5", "rx pass-through", 1, 0);
    if (!eof) return;
    @(negedge clk);
    s_rx_valid = 0; s_rx_sof = 0; s_rx_eof = 0;
    #1;
    exp_good = (len >= 2) && (ref_crc(len - 2) == {fr[len-1], fr[len-2]});
    check(rx_done && !early, "R6", "rx_done pulse after eof", rx_done, 1);
    check(rx_fcs_ok == exp_good && rx_fcs_err == !exp_good, req, "rx fcs flags",
          {rx_fcs_ok, rx_fcs_err}, {exp_good, !exp_good});
    @(negedge clk);
    check(!rx_done && !rx_fcs_ok && !rx_fcs_err, "R6", "status pulse single cycle",
          {rx_done, rx_fcs_ok, rx_fcs_err}, 0);
  endtask

  task automatic add_fcs(input int plen);
    logic [15:0] c;
    c = ref_crc(plen);
    fr[plen] = c[7:0];
    fr[plen+1] = c[15:8];
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(!m_tx_valid, "R10", "m_tx_valid after reset", m_tx_valid, 0);
    check(!rx_done && !rx_fcs_ok && !rx_fcs_err, "R10", "rx status after reset",
          {rx_done, rx_fcs_ok, rx_fcs_err}, 0);
  endtask

  task automatic t_check_value();
    for (int i = 0; i < 9; i++) fr[i] = 8'h31 + 8'(i);
    check(ref_crc(9) == 16'h2189, "R1", "bench model check value", ref_crc(9), 16'h2189);
    run_tx(9, 0, 0, 0, "R1");
    check(got[9] == 8'h89 && got[10] == 8'h21, "R2", "fcs octets low first",
          {got[9], got[10]}, 16'h8921);
  endtask

  task automatic t_tx_stall();
    for (int i = 0; i < 6; i++) fr[i] = 8'hA5 ^ 8'(i * 37);
    run_tx(6, 0, 0, 2, "R4");
    run_tx(6, 0, 0, 3, "R4");
  endtask

  task automatic t_tx_suppress();
    for (int i = 0; i < 5; i++) fr[i] = 8'(i * 19 + 3);
    run_tx(5, 1, 1, 0, "R3");
    run_tx(5, 0, 1, 0, "R3");
  endtask

  task automatic t_tx_single();
    fr[0] = 8'h7E;
    run_tx(1, 0, 0, 0, "R2");
    run_tx(1, 1, 0, 2, "R3");
  endtask

  task automatic t_rx_good_bad();
    for (int i = 0; i < 7; i++) fr[i] = 8'(i * 53 + 11);
    add_fcs(7);
    run_rx(9, 1, 0, "R7");
    fr[3] = fr[3] ^ 8'h10;
    run_rx(9, 1, 0, "R7");
    fr[3] = fr[3] ^ 8'h10;
    fr[8] = fr[8] ^ 8'h01;
    run_rx(9, 1, 2, "R7");
  endtask

  task automatic t_rx_short();
    fr[0] = 8'h00;
    run_rx(1, 1, 0, "R8");
    fr[0] = 8'h00; fr[1] = 8'h00;
    run_rx(2, 1, 0, "R7");
  endtask

  task automatic t_restart();
    for (int i = 0; i < 4; i++) fr[i] = 8'hF0 | 8'(i);
    run_rx(4, 0, 0, "R9");
    for (int i = 0; i < 5; i++) fr[i] = 8'(i + 100);
    add_fcs(5);
    run_rx(7, 1, 0, "R9");
    fr[0] = 8'h55; fr[1] = 8'h12;
    run_rx(2, 1, 0, "R9");
    for (int i = 0; i < 5; i++) fr[i] = 8'(i + 100);
    add_fcs(5);
    run_rx(7, 1, 3, "R9");
    for (int i = 0; i < 3; i++) fr[i] = 8'(i * 7);
    run_tx(3, 0, 0, 0, "R9");
    run_tx(3, 0, 0, 0, "R9");
  endtask

  initial begin
    t_reset();
    t_check_value();
    t_tx_stall();
    t_tx_suppress();
    t_tx_single();
    t_rx_good_bad();
    t_rx_short();
    t_restart();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule